// File: doc/BRIEF.md
# Dual-Structure 16-bit Pseudo-Random Sequence Generator

This block is a 16-bit maximal-length shift-register sequence generator that moves forward one step on every clock where its step enable is high. It can be built two ways. In the many-to-one structure, one parity of the tapped bits enters the vacant top bit. In the one-to-many structure, a toggle mask is applied across the register whenever the bit leaving the bottom is 1. A second option swaps XOR feedback for XNOR feedback. The XNOR register runs through the complement of the XOR sequence, so its illegal state is all-ones and a register cleared to zero can start without a seed.

The structure and the feedback type are captured only at reset and at a seed load. They therefore never change while the register is stepping. A seed load takes priority over stepping. If the seed is the illegal value for the chosen feedback type, the state is replaced with a legal one. The parallel state and its low bit, which is the serial stream, come straight from the register. A combinational flag reports when the state equals the illegal value for the captured feedback type.

Top module: `prng16_core`

## Requirements
- R1: In the many-to-one structure with XOR feedback, one step shifts the state right by one and writes bit 0 ^ bit 2 ^ bit 3 ^ bit 5 of the old state into bit 15, so 0xACE1 becomes 0x5670.
- R2: In the one-to-many structure with XOR feedback, one step shifts the state right by one and then XORs it with 0xB400 if old bit 0 was 1, so 0xACE1 becomes 0xE270.
- R3: With XNOR feedback (xnor_sel=1), the next state in either structure is the bitwise complement of the XOR next state of the complemented current state.
- R4: serial_bit always equals bit 0 of state_q.
- R5: With seed_load=0 and step_en=0 the state holds, whatever seed_val, struct_sel and xnor_sel do.
- R6: seed_load=1 wins over step_en. A legal seed appears on state_q after that clock edge.
- R7: A seed equal to the illegal value (0x0000 with xnor_sel=0, 0xFFFF with xnor_sel=1) is replaced with 0x0001 or 0xFFFE respectively.
- R8: A clock with rst_n=0 captures struct_sel (0 = many-to-one, 1 = one-to-many) and xnor_sel. It sets the state to 0x0001 for XOR and to 0x0000 for XNOR.
- R9: struct_sel and xnor_sel are captured only at reset or at a seed load. Changing them at other times has no effect on the stepping.
- R10: lockup is high exactly when state_q equals 0x0000 under captured XOR or 0xFFFF under captured XNOR. Since reset and loads never produce those values, it stays low.
- R11: With XOR feedback, the state 0xACE1 first returns to itself after exactly 65535 steps, in both structures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| step_en | input | 1 | Advance one step this clock |
| seed_load | input | 1 | Load seed_val and capture mode inputs |
| seed_val | input | 16 | Seed value |
| struct_sel | input | 1 | 0 many-to-one, 1 one-to-many |
| xnor_sel | input | 1 | 0 XOR feedback, 1 XNOR feedback |
| state_q | output | 16 | Parallel register state |
| serial_bit | output | 1 | Serial output, state bit 0 |
| lockup | output | 1 | State equals the illegal value |

## Verification
Directed seeds of 0xACE1 and its complement tell the two structures apart. They also separate XOR from XNOR feedback on a single step with a known answer. Seeds of all-zeros and all-ones show whether the illegal-seed substitution depends on the feedback type. Long constrained-random runs mix loads, idle cycles and mode-input changes between loads, and they expose any mode leakage or any wrong priority between load and step. Two full-period runs from 0xACE1 show that each structure's tap set or mask is really maximal.

// File: rtl/prng_pkg.sv
// Shared types for the sequence generator: structure and feedback selectors.
package prng_pkg;
    typedef enum logic {
        ST_MANY_TO_ONE = 1'b0,
        ST_ONE_TO_MANY = 1'b1
    } prng_struct_e;

    typedef enum logic {
        FB_PLAIN_XOR = 1'b0,
        FB_INV_XNOR  = 1'b1
    } prng_fb_e;
endpackage

// File: rtl/prng_fib_next.sv
// Next-state logic for the many-to-one structure.
// Assumes TAP_MASK marks the state bits whose parity feeds the top bit
// and that the mask holds an even number of taps, so XNOR feedback equals
// the complement-domain form used here.
module prng_fib_next #(
    parameter int          W        = 16,
    parameter logic [W-1:0] TAP_MASK = 16'h002D
) (
    input  logic [W-1:0] cur,
    input  logic         inv,
    output logic [W-1:0] nxt
);
    logic [W-1:0] src;
    logic [W-1:0] tapped;
    logic         fb;
    logic [W-1:0] raw;

    assign src = inv ? ~cur : cur;

    // Select each tapped bit; untapped positions contribute zero.
    for (genvar i = 0; i < W; i++) begin : g_tap
        if (TAP_MASK[i]) begin : g_on
            assign tapped[i] = src[i];
        end else begin : g_off
            assign tapped[i] = 1'b0;
        end
    end

    assign fb  = ^tapped;
    assign raw = {fb, src[W-1:1]};
    assign nxt = inv ? ~raw : raw;
endmodule

// File: rtl/prng_gal_next.sv
// Next-state logic for the one-to-many structure.
// Assumes TOGGLE_MASK is already aligned to the right-shifted state
// (top bit set for the term that re-enters at the top).
module prng_gal_next #(
    parameter int           W           = 16,
    parameter logic [W-1:0] TOGGLE_MASK = 16'hB400
) (
    input  logic [W-1:0] cur,
    input  logic         inv,
    output logic [W-1:0] nxt
);
    logic [W-1:0] src;
    logic [W-1:0] shifted;
    logic [W-1:0] raw;

    assign src     = inv ? ~cur : cur;
    assign shifted = {1'b0, src[W-1:1]};

    // Apply the toggle mask only when the bit leaving the register was 1.
    always_comb begin
        raw = shifted;
        if (src[0]) raw = shifted ^ TOGGLE_MASK;
    end

    assign nxt = inv ? ~raw : raw;
endmodule

// File: rtl/prng16_core.sv
// Dual-structure sequence generator top.
// It captures the structure and feedback inputs at reset and at a seed
// load, steps on step_en, and replaces illegal seeds with a legal value.
// Assumes the mode inputs are meant to be read only at those two events.
module prng16_core
    import prng_pkg::*;
#(
    parameter int           W         = 16,
    parameter logic [W-1:0] FIB_TAPS  = 16'h002D,
    parameter logic [W-1:0] GAL_MASK  = 16'hB400
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_en,
    input  logic         seed_load,
    input  logic [15:0]  seed_val,
    input  logic         struct_sel,
    input  logic         xnor_sel,
    output logic [15:0]  state_q,
    output logic         serial_bit,
    output logic         lockup
);
    localparam logic [W-1:0] ALL_ZERO  = '0;
    localparam logic [W-1:0] ALL_ONE   = '1;
    localparam logic [W-1:0] SAFE_XOR  = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] SAFE_XNOR = ~SAFE_XOR;

    prng_struct_e struct_q;
    prng_fb_e     fb_q;
    logic [W-1:0] nxt_fib;
    logic [W-1:0] nxt_gal;
    logic [W-1:0] nxt_sel;
    logic [W-1:0] seed_fixed;
    logic         inv_q;

    assign inv_q = (fb_q == FB_INV_XNOR);

    prng_fib_next #(.W(W), .TAP_MASK(FIB_TAPS)) u_fib (
        .cur(state_q), .inv(inv_q), .nxt(nxt_fib)
    );

    prng_gal_next #(.W(W), .TOGGLE_MASK(GAL_MASK)) u_gal (
        .cur(state_q), .inv(inv_q), .nxt(nxt_gal)
    );

    // Pick the next state of the captured structure.
    always_comb begin
        nxt_sel = (struct_q == ST_ONE_TO_MANY) ? nxt_gal : nxt_fib;
    end

    // Replace a seed equal to the illegal value of the requested feedback type.
    always_comb begin
        seed_fixed = seed_val;
        if (xnor_sel && seed_val == ALL_ONE)   seed_fixed = SAFE_XNOR;
        if (!xnor_sel && seed_val == ALL_ZERO) seed_fixed = SAFE_XOR;
    end

    // State and mode register: reset, then load, then step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            struct_q <= prng_struct_e'(struct_sel);
            fb_q     <= prng_fb_e'(xnor_sel);
            state_q  <= xnor_sel ? ALL_ZERO : SAFE_XOR;
        end else if (seed_load) begin
            struct_q <= prng_struct_e'(struct_sel);
            fb_q     <= prng_fb_e'(xnor_sel);
            state_q  <= seed_fixed;
        end else if (step_en) begin
            state_q  <= nxt_sel;
        end
    end

    assign serial_bit = state_q[0];
    assign lockup     = inv_q ? (state_q == ALL_ONE) : (state_q == ALL_ZERO);

    // R1: many-to-one XOR step shifts right by one position.
    a_r1_fib_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (!seed_load && step_en && struct_q == ST_MANY_TO_ONE && fb_q == FB_PLAIN_XOR)
        |=> state_q[W-2:0] == $past(state_q[W-1:1]));

    // R2: one-to-many XOR step, untouched low bits are a plain shift.
    a_r2_gal_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!seed_load && step_en && struct_q == ST_ONE_TO_MANY && fb_q == FB_PLAIN_XOR)
        |=> state_q[9:0] == $past(state_q[10:1]));

    // R5: no load and no step keeps the state.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!seed_load && !step_en) |=> $stable(state_q));

    // R6: a legal seed is taken as is, even with step_en high.
    a_r6_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_load && (xnor_sel ? seed_val != ALL_ONE : seed_val != ALL_ZERO))
        |=> state_q == $past(seed_val));

    // R7: an all-ones seed under XNOR becomes the safe value.
    a_r7_xnor_fix: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_load && xnor_sel && seed_val == ALL_ONE) |=> state_q == SAFE_XNOR);

    // R9: the captured modes change only at a load.
    a_r9_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !seed_load |=> ($stable(struct_q) && $stable(fb_q)));

    // R10: the register never sits in its illegal state.
    a_r10_never_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !lockup);
endmodule

// File: tb/sim_prng16_core.sv
module sim_prng16_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_en = 1'b0;
    logic        seed_load = 1'b0;
    logic [15:0] seed_val = 16'h0;
    logic        struct_sel = 1'b0;
    logic        xnor_sel = 1'b0;
    logic [15:0] state_q;
    logic        serial_bit;
    logic        lockup;

    int n_chk = 0;
    int n_bad = 0;
    logic        done = 1'b0;

    logic [15:0] m_state;
    logic        m_gal;
    logic        m_inv;

    always #4 clk = ~clk;

    prng16_core u0 (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .seed_load(seed_load),
        .seed_val(seed_val), .struct_sel(struct_sel), .xnor_sel(xnor_sel),
        .state_q(state_q), .serial_bit(serial_bit), .lockup(lockup)
    );

    function automatic logic [15:0] fib_x(input logic [15:0] s);
        return {s[0] ^ s[2] ^ s[3] ^ s[5], s[15:1]};
    endfunction

    function automatic logic [15:0] gal_x(input logic [15:0] s);
        return (s >> 1) ^ (s[0] ? 16'hB400 : 16'h0000);
    endfunction

    function automatic logic [15:0] ref_next(input logic [15:0] s, input logic g, input logic inv);
        logic [15:0] t;
        t = inv ? ~s : s;
        t = g ? gal_x(t) : fib_x(t);
        return inv ? ~t : t;
    endfunction

    function automatic logic [15:0] ref_seed(input logic [15:0] s, input logic inv);
        if (inv && s == 16'hFFFF) return 16'hFFFE;
        if (!inv && s == 16'h0000) return 16'h0001;
        return s;
    endfunction

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic chk_outputs(input string tag);
        chk({tag, " state"}, state_q, m_state);
        chk("R4 serial", {15'h0, serial_bit}, {15'h0, m_state[0]});
        chk("R10 lockup", {15'h0, lockup}, 16'h0);
    endtask

    // One clock: inputs driven at the falling edge, outputs read at the next.
    task automatic cyc(input logic ld, input logic en, input logic [15:0] sd,
                       input logic st, input logic xn);
        seed_load = ld; step_en = en; seed_val = sd; struct_sel = st; xnor_sel = xn;
        @(posedge clk);
        @(negedge clk);
        if (ld) begin
            m_gal = st; m_inv = xn; m_state = ref_seed(sd, xn);
        end else if (en) begin
            m_state = ref_next(m_state, m_gal, m_inv);
        end
    endtask

    task automatic do_reset(input logic st, input logic xn);
        rst_n = 1'b0; seed_load = 1'b0; step_en = 1'b0;
        struct_sel = st; xnor_sel = xn;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_gal = st; m_inv = xn; m_state = xn ? 16'h0000 : 16'h0001;
    endtask

    task automatic period_run(input logic st, input string tag);
        int n;
        cyc(1'b1, 1'b0, 16'hACE1, st, 1'b0);
        n = 0;
        seed_load = 1'b0; step_en = 1'b1;
        for (int i = 0; i < 70000; i++) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (state_q == 16'hACE1) break;
        end
        step_en = 1'b0;
        chk(tag, n[15:0], 16'hFFFF);
        m_state = 16'hACE1;
    endtask

    initial begin
        @(negedge clk);
        do_reset(1'b0, 1'b0);
        chk_outputs("R8 reset xor");
        do_reset(1'b1, 1'b1);
        chk_outputs("R8 reset xnor");

        cyc(1'b1, 1'b0, 16'hACE1, 1'b0, 1'b0); chk_outputs("R6 load");
        cyc(1'b0, 1'b1, 16'h0, 1'b0, 1'b0);     chk("R1 fib step", state_q, 16'h5670);
        cyc(1'b1, 1'b0, 16'hACE1, 1'b1, 1'b0);
        cyc(1'b0, 1'b1, 16'h0, 1'b0, 1'b0);     chk("R2 gal step", state_q, 16'hE270);
        cyc(1'b1, 1'b0, 16'h531E, 1'b0, 1'b1);
        cyc(1'b0, 1'b1, 16'h0, 1'b1, 1'b0);     chk("R3 fib xnor", state_q, 16'hA98F);
        cyc(1'b1, 1'b0, 16'h531E, 1'b1, 1'b1);
        cyc(1'b0, 1'b1, 16'h0, 1'b0, 1'b0);     chk("R3 gal xnor", state_q, 16'h1D8F);

        cyc(1'b1, 1'b0, 16'h0000, 1'b0, 1'b0);  chk("R7 zero seed", state_q, 16'h0001);
        cyc(1'b1, 1'b0, 16'hFFFF, 1'b1, 1'b1);  chk("R7 ones seed", state_q, 16'hFFFE);
        cyc(1'b1, 1'b0, 16'hFFFF, 1'b0, 1'b0);  chk("R7 ones under xor", state_q, 16'hFFFF);
        cyc(1'b1, 1'b0, 16'h0000, 1'b1, 1'b1);  chk("R7 zero under xnor", state_q, 16'h0000);

        cyc(1'b1, 1'b1, 16'h1234, 1'b0, 1'b0);  chk("R6 load over step", state_q, 16'h1234);
        cyc(1'b0, 1'b0, 16'hBEEF, 1'b1, 1'b1);  chk("R5 hold", state_q, 16'h1234);
        cyc(1'b0, 1'b1, 16'h0, 1'b1, 1'b1);     chk_outputs("R9 mode ignored");
        cyc(1'b0, 1'b1, 16'h0, 1'b1, 1'b0);     chk_outputs("R9 mode ignored");

        void'($urandom(32'd2024));
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] r;
            logic [15:0] sd;
            r = 4'($urandom());
            sd = 16'($urandom());
            if (r == 4'd0) sd = 16'h0000;
            if (r == 4'd1) sd = 16'hFFFF;
            cyc(r < 4'd3, r > 4'd5, sd, 1'($urandom()), 1'($urandom()));
            chk_outputs("R1/R2/R3/R5/R6/R9 random");
        end

        period_run(1'b0, "R11 fib period");
        period_run(1'b1, "R11 gal period");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule